// File: doc/BRIEF.md
# Auxiliary SAR Converter Sequencer

This block sequences two independent 10-bit successive-approximation converters, channel A and channel B. Both run from one timing source, the receive-converter clock. A register bit selects whether the auxiliary conversion clock is that clock divided by 2 or divided by 4. The block also drives each channel's analog input-select and reference-select controls from register bits. The comparator, trial DAC and reference buffer are outside the block.

A one-cycle start request on a channel launches a conversion. The conversion spends one auxiliary clock period on setup. It then resolves the result from MSB to LSB: the block presents a trial code on `trial_*_o`, samples the external comparator, and keeps or clears each bit in turn. The trial code advances at twice the auxiliary clock rate, so all 10 bits fit inside the eight auxiliary periods of one conversion. After the last period the result register is loaded and a one-cycle done pulse is raised.

Top module: `aux_sar_seq`

## Requirements
- R1: After reset, `mux_sel_*_o` is 0 (input 2 chosen), `int_ref_en_*_o` is 1, `aux_clk_o` is 0, and `result_*_o`, `done_*_o` and `busy_*_o` are 0.
- R2: `mux_sel_*_o` follows `sel_in1_*_i` one clock later. A value of 1 selects input 1 and a value of 0 selects input 2.
- R3: `int_ref_en_*_o` is the inverse of `ref_ext_*_i`, delayed by one clock. When `ref_ext_*_i` is 1 the internal reference is disabled and the external reference is used.
- R4: `aux_clk_o` toggles every clock when `div4_i` is 0, giving a period of 2 receive clocks. It toggles every second clock when `div4_i` is 1, giving a period of 4.
- R5: A conversion lasts 16 receive clocks in divide-by-2 mode and 32 in divide-by-4 mode. The count runs from the edge that accepts the start to the edge that raises done.
- R6: For each bit from MSB to LSB, the block sets the bit in the trial code and samples `cmp_*_i`. It keeps the bit if the comparator is 1 (input at or above the trial level) and clears it otherwise. The trial code is 0 when a conversion begins, so a comparator that reports `vin >= trial` yields a result equal to vin.
- R7: `done_*_o` is high for exactly one clock. That is the first clock in which `result_*_o` shows the new value, and `busy_*_o` is already low in it. Between done pulses, `result_*_o` does not change.
- R8: A start on a channel that is busy is ignored. The running conversion ends on its original schedule, its result is unaffected, and no second done follows.
- R9: The divide-select value is captured when a conversion is accepted. Changing `div4_i` during a conversion does not alter that conversion's length. The new value applies from the next start.
- R10: Channels A and B convert at the same time and independently, each producing its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive-converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div4_i | input | 1 | Register bit: 0 selects divide by 2, 1 selects divide by 4 |
| sel_in1_a_i | input | 1 | Register bit: channel A input select |
| sel_in1_b_i | input | 1 | Register bit: channel B input select |
| ref_ext_a_i | input | 1 | Register bit: channel A external reference |
| ref_ext_b_i | input | 1 | Register bit: channel B external reference |
| start_a_i | input | 1 | Channel A conversion start pulse |
| start_b_i | input | 1 | Channel B conversion start pulse |
| cmp_a_i | input | 1 | Channel A comparator, 1 = input at or above trial level |
| cmp_b_i | input | 1 | Channel B comparator |
| aux_clk_o | output | 1 | Divided auxiliary conversion clock |
| mux_sel_a_o | output | 1 | Channel A analog mux select, 1 = input 1 |
| mux_sel_b_o | output | 1 | Channel B analog mux select |
| int_ref_en_a_o | output | 1 | Channel A internal reference enable |
| int_ref_en_b_o | output | 1 | Channel B internal reference enable |
| trial_a_o | output | 10 | Channel A trial DAC code |
| trial_b_o | output | 10 | Channel B trial DAC code |
| result_a_o | output | 10 | Channel A result |
| result_b_o | output | 10 | Channel B result |
| done_a_o | output | 1 | Channel A result-valid pulse |
| done_b_o | output | 1 | Channel B result-valid pulse |
| busy_a_o | output | 1 | Channel A conversion in progress |
| busy_b_o | output | 1 | Channel B conversion in progress |

## Verification
The comparator is modelled as `vin >= trial`, so a correct sequence returns vin exactly. Both channels are driven at the same time with different inputs. The input set covers the extremes 0 and 1023, the adjacent pair 512/511 (which differ in every bit and so expose an MSB or keep/clear inversion), the alternating patterns 341/682, and values 1 and 1022 that exercise only the LSB end. The same vectors run in both divide modes, which separates a wrong step count from a wrong bit decision. Directed runs add a second start during a conversion and toggle the divide select during a conversion, to show that neither changes the timing in progress.

// File: rtl/aux_sar_pkg.sv
package aux_sar_pkg;
  localparam int RES_W       = 10;
  localparam int CONV_STEPS  = 16;  // half aux periods per conversion
  localparam int SETUP_STEPS = 2;   // one aux period

  typedef struct packed {
    logic div4;
    logic sel_in1_a;
    logic sel_in1_b;
    logic ref_ext_a;
    logic ref_ext_b;
  } aux_cfg_t;
endpackage

// File: rtl/aux_cfg_reg.sv
module aux_cfg_reg
  import aux_sar_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  aux_cfg_t cfg_i,
  output aux_cfg_t cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_o <= '0;
    else         cfg_o <= cfg_i;
  end
endmodule

// File: rtl/aux_clk_div.sv
module aux_clk_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div4_i,
  output logic aux_clk_o
);
  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q    <= 1'b0;
      aux_clk_o <= 1'b0;
    end else if (!div4_i || half_q) begin
      half_q    <= 1'b0;
      aux_clk_o <= ~aux_clk_o;
    end else begin
      half_q    <= 1'b1;
    end
  end
endmodule

// File: rtl/aux_sar_chan.sv
module aux_sar_chan #(
  parameter int RES_W       = 10,
  parameter int CONV_STEPS  = 16,
  parameter int SETUP_STEPS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div4_i,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int SW = $clog2(CONV_STEPS);
  localparam logic [SW-1:0] LAST_STEP   = SW'(CONV_STEPS - 1);
  localparam logic [SW-1:0] PRE_TRIAL   = SW'(SETUP_STEPS - 1);
  localparam logic [SW-1:0] FIRST_TRIAL = SW'(SETUP_STEPS);
  localparam logic [SW-1:0] LAST_TRIAL  = SW'(SETUP_STEPS + RES_W - 1);

  logic             div4_q, sub_q;
  logic [SW-1:0]    step_q;
  logic [RES_W-1:0] code_q;
  logic             step_end, in_trial;
  logic [SW-1:0]    bit_idx;

  assign step_end = !div4_q || sub_q;
  assign in_trial = (step_q >= FIRST_TRIAL) && (step_q <= LAST_TRIAL);
  assign bit_idx  = LAST_TRIAL - step_q;
  assign trial_o  = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      div4_q   <= 1'b0;
      sub_q    <= 1'b0;
      step_q   <= '0;
      code_q   <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          div4_q <= div4_i;  // mode frozen for this conversion
          sub_q  <= 1'b0;
          step_q <= '0;
          code_q <= '0;
        end
      end else if (!step_end) begin
        sub_q <= 1'b1;
      end else begin
        sub_q  <= 1'b0;
        step_q <= step_q + 1'b1;
        if (step_q == PRE_TRIAL) begin
          code_q <= {1'b1, {(RES_W-1){1'b0}}};
        end else if (in_trial) begin
          code_q[bit_idx] <= cmp_i;
          if (bit_idx != '0) code_q[bit_idx - 1'b1] <= 1'b1;
        end
        if (step_q == LAST_STEP) begin
          busy_o   <= 1'b0;
          result_o <= code_q;
          done_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aux_sar_seq.sv
module aux_sar_seq
  import aux_sar_pkg::*;
#(
  parameter int RES_W       = aux_sar_pkg::RES_W,
  parameter int CONV_STEPS  = aux_sar_pkg::CONV_STEPS,
  parameter int SETUP_STEPS = aux_sar_pkg::SETUP_STEPS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div4_i,
  input  logic             sel_in1_a_i,
  input  logic             sel_in1_b_i,
  input  logic             ref_ext_a_i,
  input  logic             ref_ext_b_i,
  input  logic             start_a_i,
  input  logic             start_b_i,
  input  logic             cmp_a_i,
  input  logic             cmp_b_i,
  output logic             aux_clk_o,
  output logic             mux_sel_a_o,
  output logic             mux_sel_b_o,
  output logic             int_ref_en_a_o,
  output logic             int_ref_en_b_o,
  output logic [RES_W-1:0] trial_a_o,
  output logic [RES_W-1:0] trial_b_o,
  output logic [RES_W-1:0] result_a_o,
  output logic [RES_W-1:0] result_b_o,
  output logic             done_a_o,
  output logic             done_b_o,
  output logic             busy_a_o,
  output logic             busy_b_o
);
  localparam int N_CH = 2;

  aux_cfg_t cfg_d, cfg_q;

  assign cfg_d = '{div4: div4_i, sel_in1_a: sel_in1_a_i, sel_in1_b: sel_in1_b_i,
                   ref_ext_a: ref_ext_a_i, ref_ext_b: ref_ext_b_i};

  aux_cfg_reg u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cfg_i (cfg_d),
    .cfg_o (cfg_q)
  );

  aux_clk_div u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div4_i   (cfg_q.div4),
    .aux_clk_o(aux_clk_o)
  );

  assign mux_sel_a_o    = cfg_q.sel_in1_a;
  assign mux_sel_b_o    = cfg_q.sel_in1_b;
  assign int_ref_en_a_o = ~cfg_q.ref_ext_a;
  assign int_ref_en_b_o = ~cfg_q.ref_ext_b;

  logic [N_CH-1:0]             start_v, cmp_v, done_v, busy_v;
  logic [N_CH-1:0][RES_W-1:0]  trial_v, result_v;

  assign start_v = {start_b_i, start_a_i};
  assign cmp_v   = {cmp_b_i, cmp_a_i};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    aux_sar_chan #(
      .RES_W      (RES_W),
      .CONV_STEPS (CONV_STEPS),
      .SETUP_STEPS(SETUP_STEPS)
    ) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .div4_i  (cfg_q.div4),
      .start_i (start_v[c]),
      .cmp_i   (cmp_v[c]),
      .trial_o (trial_v[c]),
      .result_o(result_v[c]),
      .done_o  (done_v[c]),
      .busy_o  (busy_v[c])
    );
  end

  assign trial_a_o  = trial_v[0];
  assign trial_b_o  = trial_v[1];
  assign result_a_o = result_v[0];
  assign result_b_o = result_v[1];
  assign done_a_o   = done_v[0];
  assign done_b_o   = done_v[1];
  assign busy_a_o   = busy_v[0];
  assign busy_b_o   = busy_v[1];
endmodule

// File: rtl/aux_sar_chk.sv
module aux_sar_chk #(
  parameter int RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_i,
  input logic             busy_i,
  input logic [RES_W-1:0] result_i,
  input logic [RES_W-1:0] trial_i
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i); // R7
  AST_DONE_ENDS_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(busy_i)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(result_i)); // R7
  AST_TRIAL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (trial_i == '0)); // R6
endmodule

bind aux_sar_seq aux_sar_chk #(.RES_W(RES_W)) u_chk_a (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_a_o), .busy_i(busy_a_o),
  .result_i(result_a_o), .trial_i(trial_a_o)
);

bind aux_sar_seq aux_sar_chk #(.RES_W(RES_W)) u_chk_b (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_b_o), .busy_i(busy_b_o),
  .result_i(result_b_o), .trial_i(trial_b_o)
);

// File: tb/aux_sar_seq_test.sv
module aux_sar_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic div4 = 0, sel_a = 0, sel_b = 0, ref_a = 0, ref_b = 0, st_a = 0, st_b = 0;
  logic [9:0] vin_a = '0, vin_b = '0;
  logic aux_clk, msel_a, msel_b, iref_a, iref_b, dn_a, dn_b, bz_a, bz_b;
  logic [9:0] tr_a, tr_b, res_a, res_b;
  logic cmp_a, cmp_b;

  assign cmp_a = (vin_a >= tr_a);
  assign cmp_b = (vin_b >= tr_b);

  aux_sar_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .div4_i(div4),
    .sel_in1_a_i(sel_a), .sel_in1_b_i(sel_b), .ref_ext_a_i(ref_a), .ref_ext_b_i(ref_b),
    .start_a_i(st_a), .start_b_i(st_b), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
    .aux_clk_o(aux_clk), .mux_sel_a_o(msel_a), .mux_sel_b_o(msel_b),
    .int_ref_en_a_o(iref_a), .int_ref_en_b_o(iref_b),
    .trial_a_o(tr_a), .trial_b_o(tr_b), .result_a_o(res_a), .result_b_o(res_b),
    .done_a_o(dn_a), .done_b_o(dn_b), .busy_a_o(bz_a), .busy_b_o(bz_b)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // div4, vin_a, vin_b
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 10'd0,    10'd1023},
    {1'b0, 10'd512,  10'd511},
    {1'b0, 10'd341,  10'd682},
    {1'b0, 10'd1,    10'd1022},
    {1'b1, 10'd1023, 10'd0},
    {1'b1, 10'd511,  10'd512},
    {1'b1, 10'd682,  10'd341},
    {1'b1, 10'd600,  10'd3}
  };

  // start both channels; optional second start on A and divide flip at given cycle
  task automatic conv(input logic [9:0] va, input logic [9:0] vb, input int ign_at,
                      input int flip_at, output int cyc, output int done_b_cyc);
    vin_a = va; vin_b = vb;
    @(negedge clk); st_a = 1; st_b = 1;
    @(negedge clk); st_a = 0; st_b = 0;
    cyc = 0; done_b_cyc = -1;
    while (!dn_a && cyc < 100) begin
      if (dn_b) done_b_cyc = cyc;
      st_a = (cyc == ign_at);
      if (cyc == flip_at) div4 = ~div4;
      @(negedge clk); cyc++;
    end
    st_a = 0;
    if (dn_b) done_b_cyc = cyc;
  endtask

  initial begin
    int cyc, cb, tog;
    logic prev;
    #1;
    check("R1 mux_sel_a reset", msel_a, 0);
    check("R1 mux_sel_b reset", msel_b, 0);
    check("R1 int_ref_en_a reset", iref_a, 1);
    check("R1 int_ref_en_b reset", iref_b, 1);
    check("R1 aux_clk reset", aux_clk, 0);
    check("R1 result_a reset", res_a, 0);
    check("R1 done/busy reset", {dn_a, dn_b, bz_a, bz_b}, 0);
    #20; @(negedge clk); rst_n = 1;
    @(negedge clk);

    // table walk: R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      div4 = VEC[i][20];
      @(negedge clk); @(negedge clk);
      conv(VEC[i][19:10], VEC[i][9:0], -1, -1, cyc, cb);
      check("R5 conversion length", cyc, div4 ? 32 : 16);
      check("R6 result A", res_a, VEC[i][19:10]);
      check("R10 result B", res_b, VEC[i][9:0]);
      check("R10 done B aligned", cb, cyc);
      check("R7 busy low at done", bz_a, 0);
      @(negedge clk);
      check("R7 done one cycle", dn_a, 0);
      check("R7 result held", res_a, VEC[i][19:10]);
    end

    // R2 R3
    sel_a = 1; ref_b = 1;
    @(negedge clk);
    check("R2 mux_sel_a high", msel_a, 1);
    check("R2 mux_sel_b low", msel_b, 0);
    check("R3 int_ref_en_b off", iref_b, 0);
    check("R3 int_ref_en_a on", iref_a, 1);
    sel_a = 0; ref_b = 0;
    @(negedge clk);
    check("R2 mux_sel_a back low", msel_a, 0);
    check("R3 int_ref_en_b back on", iref_b, 1);

    // R4
    for (int m = 0; m < 2; m++) begin
      div4 = m[0];
      repeat (3) @(negedge clk);
      tog = 0; prev = aux_clk;
      repeat (8) begin
        @(negedge clk);
        if (aux_clk != prev) tog++;
        prev = aux_clk;
      end
      check(m ? "R4 toggles div4" : "R4 toggles div2", tog, m ? 4 : 8);
    end

    // R8: second start mid-conversion ignored
    div4 = 0; @(negedge clk); @(negedge clk);
    conv(10'd300, 10'd77, 5, -1, cyc, cb);
    check("R8 length with extra start", cyc, 16);
    check("R8 result with extra start", res_a, 300);
    tog = 0;
    repeat (40) begin @(negedge clk); if (dn_a || bz_a) tog++; end
    check("R8 no second conversion", tog, 0);

    // R9: flip divide select mid-conversion
    div4 = 0; @(negedge clk); @(negedge clk);
    conv(10'd900, 10'd55, -1, 4, cyc, cb);
    check("R9 length unchanged by flip", cyc, 16);
    check("R9 result after flip", res_a, 900);
    @(negedge clk); @(negedge clk);
    conv(10'd123, 10'd456, -1, -1, cyc, cb);
    check("R9 new mode at next start", cyc, 32);
    check("R9 result next start", res_a, 123);

    finished = 1;
  end

  initial begin
    int w = 0;
    while (!finished && w < 20000) begin @(posedge clk); w++; end
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected finish", w);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule